// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block sits behind a per-lane 64-bit operation in a packed vector unit. It receives one operation per strobe and carries a 512-bit source vector, a 64-bit scalar operand for broadcast, the old destination value, a per-lane write mask and a vector-length select. For each lane it picks the operand, runs it through one copy of the scalar lane function, and builds the new 512-bit destination. Under merging masking a masked-off lane keeps its old value. Under zeroing masking the lane is cleared. Every bit above the active vector length is forced to zero.

The lane function is chosen by a parameter, so the same wrapper can serve any 64-bit elementwise operation. The default variant is an integer increment, which is easy to check. Each lane also returns a small set of exception flags. The block gathers these by OR, but only from lanes whose result is actually written. The destination, the flags and a valid bit are registered, so they appear one cycle after the strobe, and all lanes change together.

Top module: `simd_masked_wb`

## Requirements
- R1: `vlen_sel` picks the active lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), and 2 or 3 give 8 lanes (512 bits).
- R2: An active lane j (bits [64j+63:64j]) takes the lane function's result when `mask_en` is 0 or when `kmask[j]` is 1.
- R3: When `bcast_en` and `src_is_mem` are both 1, every lane's operand is `bcast_elem`. Otherwise lane j's operand is `src_vec[64j+63:64j]`, even when `bcast_en` is 1 alone.
- R4: With `mask_en`=1 and `zero_mode`=0, an active lane whose mask bit is 0 keeps its `old_dst` value.
- R5: With `mask_en`=1 and `zero_mode`=1, an active lane whose mask bit is 0 becomes zero.
- R6: All destination bits above the active length, up to bit 511, are zero, whatever `old_dst`, `kmask` and `zero_mode` are.
- R7: Mask bits at or above the active lane count have no effect on the destination or the flags.
- R8: `flags` is the bitwise OR of the lane flags of the written lanes only. When no lane is written, `flags` is zero.
- R9: `dst_vec`, `flags` and `out_valid` update on the clock edge that samples `in_valid`=1, all lanes together. `out_valid` is 1 exactly in the cycle after a strobe. Without a strobe, `dst_vec` and `flags` hold their values.
- R10: While `rst_n` is low, `out_valid`, `dst_vec` and `flags` are zero.
- R11: The default lane function returns the operand plus 1, modulo 2^64. Its flag bit 0 is set when the operand is all ones (wrap). Its flag bit 1 is operand bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 512 | Packed source vector, eight 64-bit elements |
| bcast_elem | input | 64 | Scalar operand used when broadcasting |
| old_dst | input | 512 | Current destination value, used for merging |
| kmask | input | 8 | Per-lane write mask |
| vlen_sel | input | 2 | Vector length select |
| mask_en | input | 1 | 1: apply `kmask`; 0: write every active lane |
| bcast_en | input | 1 | Broadcast request |
| src_is_mem | input | 1 | Operand comes from memory |
| zero_mode | input | 1 | 1: zeroing masking; 0: merging masking |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| dst_vec | output | 512 | Registered destination value |
| flags | output | 2 | OR of the written lanes' exception flags |

## Verification
Two functions meet on the same lane in one cycle. Upper-length clearing can hit a lane whose mask bit is set and which would otherwise be merged or written. Broadcasting can also feed a wrapping operand to a lane whose flags must stay out of the OR because it is masked off. The bench provokes both cases on purpose. It uses a short vector length with stray high mask bits and an all-ones `old_dst`, and it broadcasts an all-ones operand with only part of the mask set. A behavioural model, built from the requirements lane by lane, judges every registered result, and fixed literal expectations are added for the directed cases.

// File: rtl/simd_wb_pkg.sv
package simd_wb_pkg;
    localparam int unsigned LANE_W    = 64;
    localparam int unsigned MAX_LANES = 8;
    localparam int unsigned FLAG_W    = 2;
    localparam int unsigned VSEL_W    = 2;
    localparam int unsigned VEC_W     = LANE_W * MAX_LANES;

    typedef enum logic [1:0] {
        LOP_INC  = 2'd0,
        LOP_PASS = 2'd1
    } lane_op_e;

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  dst;
        logic [FLAG_W-1:0] flags;
    } wb_state_t;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
    import simd_wb_pkg::*;
#(
    parameter int unsigned W  = LANE_W,
    parameter int unsigned FW = FLAG_W,
    parameter lane_op_e    OP = LOP_INC
) (
    input  logic [W-1:0]  opnd,
    output logic [W-1:0]  res,
    output logic [FW-1:0] lflags
);
    generate
        if (OP == LOP_INC) begin : g_inc
            always_comb begin
                res       = opnd + W'(1);
                lflags    = '0;
                lflags[0] = &opnd;
                lflags[1] = opnd[W-1];
            end
        end else begin : g_pass
            always_comb begin
                res    = opnd;
                lflags = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/simd_vlen_dec.sv
module simd_vlen_dec
    import simd_wb_pkg::*;
#(
    parameter int unsigned NL = MAX_LANES,
    parameter int unsigned SW = VSEL_W
) (
    input  logic [SW-1:0] vlen_sel,
    output logic [NL-1:0] active
);
    logic [31:0] lane_cnt;

    always_comb begin
        lane_cnt = 32'd2 << vlen_sel;
        if (lane_cnt > NL) begin
            lane_cnt = NL;
        end
    end

    generate
        for (genvar j = 0; j < NL; j++) begin : g_act
            assign active[j] = (32'(j) < lane_cnt);
        end
    endgenerate
endmodule

// File: rtl/simd_lane_slice.sv
module simd_lane_slice
    import simd_wb_pkg::*;
#(
    parameter int unsigned W  = LANE_W,
    parameter int unsigned FW = FLAG_W,
    parameter lane_op_e    OP = LOP_INC
) (
    input  logic [W-1:0]  own_elem,
    input  logic [W-1:0]  bcast_elem,
    input  logic [W-1:0]  old_elem,
    input  logic          use_bcast,
    input  logic          lane_active,
    input  logic          lane_wr,
    input  logic          zero_mode,
    output logic [W-1:0]  lane_next,
    output logic [FW-1:0] lane_flags
);
    logic [W-1:0]  opnd;
    logic [W-1:0]  res;
    logic [FW-1:0] lflags;

    assign opnd = use_bcast ? bcast_elem : own_elem;

    simd_lane_op #(.W(W), .FW(FW), .OP(OP)) u_op (
        .opnd   (opnd),
        .res    (res),
        .lflags (lflags)
    );

    always_comb begin
        if (!lane_active) begin
            lane_next  = '0;
            lane_flags = '0;
        end else if (lane_wr) begin
            lane_next  = res;
            lane_flags = lflags;
        end else begin
            lane_next  = zero_mode ? '0 : old_elem;
            lane_flags = '0;
        end
    end
endmodule

// File: rtl/simd_masked_wb.sv
module simd_masked_wb
    import simd_wb_pkg::*;
#(
    parameter lane_op_e LANE_OP = LOP_INC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [LANE_W-1:0]    bcast_elem,
    input  logic [VEC_W-1:0]     old_dst,
    input  logic [MAX_LANES-1:0] kmask,
    input  logic [VSEL_W-1:0]    vlen_sel,
    input  logic                 mask_en,
    input  logic                 bcast_en,
    input  logic                 src_is_mem,
    input  logic                 zero_mode,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     dst_vec,
    output logic [FLAG_W-1:0]    flags
);
    logic [MAX_LANES-1:0] active;
    logic [MAX_LANES-1:0] lane_wr;
    logic                 use_bcast;
    logic [VEC_W-1:0]     vec_next;
    logic [FLAG_W-1:0]    lane_flags [MAX_LANES];
    wb_state_t            st_d, st_q;

    simd_vlen_dec #(.NL(MAX_LANES), .SW(VSEL_W)) u_vdec (
        .vlen_sel (vlen_sel),
        .active   (active)
    );

    assign use_bcast = bcast_en & src_is_mem;
    assign lane_wr   = mask_en ? kmask : '1;

    generate
        for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
            simd_lane_slice #(.W(LANE_W), .FW(FLAG_W), .OP(LANE_OP)) u_slice (
                .own_elem    (src_vec[j*LANE_W +: LANE_W]),
                .bcast_elem  (bcast_elem),
                .old_elem    (old_dst[j*LANE_W +: LANE_W]),
                .use_bcast   (use_bcast),
                .lane_active (active[j]),
                .lane_wr     (lane_wr[j]),
                .zero_mode   (zero_mode),
                .lane_next   (vec_next[j*LANE_W +: LANE_W]),
                .lane_flags  (lane_flags[j])
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.dst   = vec_next;
            st_d.flags = '0;
            for (int j = 0; j < MAX_LANES; j++) begin
                st_d.flags = st_d.flags | lane_flags[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign dst_vec   = st_q.dst;
    assign flags     = st_q.flags;
endmodule

// File: rtl/simd_masked_wb_chk.sv
module simd_masked_wb_chk
    import simd_wb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [MAX_LANES-1:0] kmask,
    input logic [VSEL_W-1:0]    vlen_sel,
    input logic                 mask_en,
    input logic                 zero_mode,
    input logic                 out_valid,
    input logic [VEC_W-1:0]     dst_vec,
    input logic [FLAG_W-1:0]    flags
);
    logic [MAX_LANES-1:0] chk_act;

    always_comb begin
        case (vlen_sel)
            2'd0:    chk_act = MAX_LANES'(8'h03);
            2'd1:    chk_act = MAX_LANES'(8'h0F);
            default: chk_act = '1;
        endcase
    end

    // R9: a strobe yields a valid result in the next cycle
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: no strobe, no valid
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: the outputs hold without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_vec) && $stable(flags)));

    // R6: a 128-bit operation leaves the upper bits zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd0) |=> (dst_vec[VEC_W-1:128] == '0));

    // R5: zeroing with no active mask bit clears everything
    a_r5_all_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && ((kmask & chk_act) == '0))
        |=> (dst_vec == '0));

    // R8: no written lane means no flags
    a_r8_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && ((kmask & chk_act) == '0)) |=> (flags == '0));
endmodule

bind simd_masked_wb simd_masked_wb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .kmask     (kmask),
    .vlen_sel  (vlen_sel),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .dst_vec   (dst_vec),
    .flags     (flags)
);

// File: tb/sim_simd_masked_wb.sv
module sim_simd_masked_wb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [63:0]  bcast_elem = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   kmask = '0;
    logic [1:0]   vlen_sel = '0;
    logic         mask_en = 1'b0;
    logic         bcast_en = 1'b0;
    logic         src_is_mem = 1'b0;
    logic         zero_mode = 1'b0;
    logic         out_valid;
    logic [511:0] dst_vec;
    logic [1:0]   flags;

    int checks = 0;
    int errors = 0;
    logic [511:0] exp_dst = '0;
    logic [1:0]   exp_flags = '0;
    logic         exp_valid = 1'b0;

    always #10 clk = ~clk;

    simd_masked_wb u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .bcast_elem(bcast_elem), .old_dst(old_dst), .kmask(kmask),
        .vlen_sel(vlen_sel), .mask_en(mask_en), .bcast_en(bcast_en),
        .src_is_mem(src_is_mem), .zero_mode(zero_mode),
        .out_valid(out_valid), .dst_vec(dst_vec), .flags(flags)
    );

    function automatic int lanes_of(input logic [1:0] v);
        if (v == 2'd0) return 2;
        if (v == 2'd1) return 4;
        return 8;
    endfunction

    // behavioural reference, updated at every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_dst   <= '0;
            exp_flags <= '0;
            exp_valid <= 1'b0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                logic [511:0] d;
                logic [1:0]   f;
                d = '0;
                f = '0;
                for (int j = 0; j < lanes_of(vlen_sel); j++) begin
                    logic [63:0] e;
                    e = (bcast_en && src_is_mem) ? bcast_elem : src_vec[j*64 +: 64];
                    if (!mask_en || kmask[j]) begin
                        d[j*64 +: 64] = e + 64'd1;
                        if (e == {64{1'b1}}) f[0] = 1'b1;
                        if (e[63]) f[1] = 1'b1;
                    end else if (!zero_mode) begin
                        d[j*64 +: 64] = old_dst[j*64 +: 64];
                    end
                end
                exp_dst   <= d;
                exp_flags <= f;
            end
        end
    end

    task automatic cmp_model(input string tag);
        checks++;
        if (dst_vec !== exp_dst || flags !== exp_flags || out_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s: dst=%h flags=%b v=%b expected dst=%h flags=%b v=%b",
                     tag, dst_vec, flags, out_valid, exp_dst, exp_flags, exp_valid);
        end
    endtask

    task automatic cmp_lit(input string tag, input logic [511:0] ed, input logic [1:0] ef);
        checks++;
        if (dst_vec !== ed || flags !== ef) begin
            errors++;
            $display("FAIL %s: dst=%h flags=%b expected dst=%h flags=%b",
                     tag, dst_vec, flags, ed, ef);
        end
    endtask

    task automatic fire(input string tag);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        cmp_model(tag);
    endtask

    logic done = 1'b0;

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9: watchdog expired, actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] ones;
        ones = {512{1'b1}};
        repeat (3) @(negedge clk);
        cmp_lit("R10 reset state", '0, 2'b00);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: out_valid=%b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R11: full length, unmasked, zero operands
        vlen_sel = 2'd2; mask_en = 1'b0; src_vec = '0; old_dst = ones;
        fire("R2 unmasked 512");
        cmp_lit("R11 increment", {8{64'd1}}, 2'b00);

        // R1 R6: 128-bit with dirty old_dst
        vlen_sel = 2'd0;
        fire("R1 128-bit");
        cmp_lit("R6 upper cleared", {384'd0, 64'd1, 64'd1}, 2'b00);

        // R1: select 3 acts as 512
        vlen_sel = 2'd3;
        fire("R1 select 3");
        cmp_lit("R1 select 3 literal", {8{64'd1}}, 2'b00);

        // R4 R7: 256-bit merging, stray high mask bits
        vlen_sel = 2'd1; mask_en = 1'b1; zero_mode = 1'b0; kmask = 8'hF5;
        for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = 64'(j * 16);
        old_dst = ones;
        fire("R4 merging");
        cmp_lit("R7 high mask ignored",
                {256'd0, {64{1'b1}}, 64'd33, {64{1'b1}}, 64'd1}, 2'b00);

        // R5: zeroing
        zero_mode = 1'b1;
        fire("R5 zeroing");
        cmp_lit("R5 zeroing literal", {256'd0, 64'd0, 64'd33, 64'd0, 64'd1}, 2'b00);

        // R7: only out-of-range mask bits set
        kmask = 8'hF0; zero_mode = 1'b0;
        fire("R7 only high bits");
        cmp_lit("R7 only high bits literal", {256'd0, {4{64'hFFFF_FFFF_FFFF_FFFF}}}, 2'b00);

        // R3: broadcast from memory
        vlen_sel = 2'd2; mask_en = 1'b0; bcast_en = 1'b1; src_is_mem = 1'b1;
        bcast_elem = 64'h8000_0000_0000_0007;
        fire("R3 broadcast");
        cmp_lit("R3 broadcast literal", {8{64'h8000_0000_0000_0008}}, 2'b10);

        // R3: broadcast without memory uses own elements
        src_is_mem = 1'b0;
        fire("R3 register source");

        // R8: wrapping broadcast into masked-off lanes only
        src_is_mem = 1'b1; bcast_elem = {64{1'b1}}; mask_en = 1'b1;
        kmask = 8'h00; zero_mode = 1'b0; old_dst = '0;
        fire("R8 masked wrap");
        cmp_lit("R8 no flags from masked lanes", '0, 2'b00);
        kmask = 8'h04;
        fire("R8 one written lane");
        cmp_lit("R8 wrap flags", '0, 2'b11);

        // R9: hold without strobe
        src_vec = ones; kmask = 8'hFF;
        @(negedge clk);
        cmp_model("R9 hold");
        cmp_lit("R9 hold literal", '0, 2'b11);

        // mixed stimulus against the model
        for (int n = 0; n < 300; n++) begin
            for (int j = 0; j < 8; j++)
                src_vec[j*64 +: 64] = ($urandom % 4 == 0) ? {64{1'b1}} : {$urandom, $urandom};
            for (int j = 0; j < 16; j++) old_dst[j*32 +: 32] = $urandom;
            bcast_elem = ($urandom % 3 == 0) ? {64{1'b1}} : {$urandom, $urandom};
            kmask = 8'($urandom);
            vlen_sel = 2'($urandom);
            mask_en = 1'($urandom); bcast_en = 1'($urandom);
            src_is_mem = 1'($urandom); zero_mode = 1'($urandom);
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                cmp_model("R9 idle mixed");
            end else begin
                fire("R2 mixed");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule